// File: doc/BRIEF.md
# Successive-Approximation Converter Controller

This block is the digital half of an 8-bit successive-approximation converter that sits on a microprocessor-style bus. It has two active-low selects and a read/write line. When the selects are both held low with the write level on read/write for long enough, a conversion starts. A busy flag is raised, and a trial code is driven to an external DAC. The trial code is refined one bit at a time, from the most significant bit down, using a single-bit comparator input. At the end the final code is stored.

The polarity select and the output-format select are captured when a conversion starts. They decide how the stored code is presented when it is read back. While no conversion is running, a read cycle places the code on a tri-stated data bus. The analog parts are external, and the bit sequencing runs from the system clock.

Top module: `sar_adc_ctrl`

## Requirements
- R1: A conversion starts only after `ce_ni`=0, `cs_ni`=0 and `rw_i`=0 have held together for MIN_CYC consecutive clock edges (default 15, which is 300 ns at 50 MHz). A shorter request leaves `status_o` low.
- R2: `status_o` rises on the edge that qualifies the start. It stays high for exactly 2*W+1 cycles (17 for W=8), then falls.
- R3: Bits are tried from MSB to LSB. Each trial takes one cycle with the bit set on `dac_o` and one cycle in which `cmp_i`=1 (DAC above input) clears the bit. With an ideal comparator, the final raw code equals the input level.
- R4: A start request that qualifies while `status_o` is high is ignored. It neither restarts nor extends the running conversion, and no conversion follows it.
- R5: `data_oe_o` is high only when `rw_i`=1, `ce_ni`=0 and `cs_ni`=0, and never while `status_o` is high. When it is low, `data_o` is released.
- R6: `bipolar_i` and `fmt_i` are sampled on the start edge. Later changes do not alter how that result is coded.
- R7: Read coding. With `bipolar_i`=0 the raw code is returned. With `bipolar_i`=1 and `fmt_i`=0 the raw code is returned (offset binary). With `bipolar_i`=1 and `fmt_i`=1 the raw code is returned with bit 7 inverted (two's complement).
- R8: While `rst_ni` is low, `status_o`=0, `dac_o`=0 and `data_oe_o`=0, even if a read is requested. After reset a read returns 0.
- R9: A request held without a break yields one conversion only. A new start needs the request to drop and then qualify again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ce_ni | input | 1 | Active-low chip enable |
| cs_ni | input | 1 | Active-low chip select |
| rw_i | input | 1 | 1 = read, 0 = start conversion |
| bipolar_i | input | 1 | 1 = bipolar range, captured at start |
| fmt_i | input | 1 | Bipolar coding: 1 = two's complement, 0 = offset binary |
| cmp_i | input | 1 | Comparator: 1 when the DAC level exceeds the input |
| dac_o | output | 8 | Trial code to the DAC |
| status_o | output | 1 | High while a conversion is in progress |
| data_o | output | 8 | Tri-stated read data |
| data_oe_o | output | 1 | Data bus drive enable |

## Verification
A read request and a running conversion can fall in the same cycle. The bench asserts a read a cycle after a start and expects the bus to stay released. A second start request and a running conversion can also coincide. The bench times a fresh request so that it qualifies on the last busy edge, then checks that busy still falls on time and never rises again. Both cases run among random input levels and mode selections, and each result is compared with the input level recoded by the captured modes.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [1:0] {
    PH_IDLE,
    PH_DRIVE,
    PH_SAMPLE,
    PH_DONE
  } sar_ph_e;
endpackage

// File: rtl/sar_start_filter.sv
module sar_start_filter #(
  parameter int unsigned MIN_CYC = 15
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  output logic start_o
);
  localparam int unsigned CW = $clog2(MIN_CYC + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (!req_i) cnt_q <= '0;
    else if (cnt_q != CW'(MIN_CYC)) cnt_q <= cnt_q + 1'b1;
  end

  // fires once, on the MIN_CYC-th consecutive request edge
  assign start_o = req_i && (cnt_q == CW'(MIN_CYC - 1));

  p_one_start_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o);

  if (MIN_CYC > 1) begin : g_width_chk
    p_min_width_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !req_i |=> !start_o);
  end
endmodule

// File: rtl/sar_seq.sv
module sar_seq
  import sar_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         cmp_i,
  input  logic         bip_i,
  input  logic         fmt_i,
  output logic         busy_o,
  output logic [W-1:0] trial_o,
  output logic [W-1:0] res_o,
  output logic         bip_o,
  output logic         fmt_o
);
  localparam int unsigned IW = (W > 1) ? $clog2(W) : 1;

  sar_ph_e        ph_q;
  logic [IW-1:0]  idx_q;
  logic [W-1:0]   trial_q, res_q;
  logic           bip_q, fmt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q    <= PH_IDLE;
      idx_q   <= '0;
      trial_q <= '0;
      res_q   <= '0;
      bip_q   <= 1'b0;
      fmt_q   <= 1'b0;
    end else begin
      case (ph_q)
        PH_IDLE: if (start_i) begin
          ph_q    <= PH_DRIVE;
          idx_q   <= IW'(W - 1);
          trial_q <= '0;
          bip_q   <= bip_i;
          fmt_q   <= fmt_i;
        end
        PH_DRIVE: begin
          trial_q[idx_q] <= 1'b1;
          ph_q           <= PH_SAMPLE;
        end
        PH_SAMPLE: begin
          if (cmp_i) trial_q[idx_q] <= 1'b0;  // DAC above input: drop bit
          if (idx_q == '0) ph_q <= PH_DONE;
          else begin
            idx_q <= idx_q - 1'b1;
            ph_q  <= PH_DRIVE;
          end
        end
        default: begin
          res_q <= trial_q;
          ph_q  <= PH_IDLE;
        end
      endcase
    end
  end

  assign busy_o  = (ph_q != PH_IDLE);
  assign trial_o = trial_q;
  assign res_o   = res_q;
  assign bip_o   = bip_q;
  assign fmt_o   = fmt_q;

  logic [W-1:0] low_mask;
  assign low_mask = (W'(1) << idx_q) - W'(1);

  p_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == PH_IDLE && start_i) |=> (ph_q == PH_DRIVE && idx_q == IW'(W - 1)));

  p_lower_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == PH_SAMPLE) |-> ((trial_q & low_mask) == '0));

  p_no_abort_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == PH_DRIVE || ph_q == PH_SAMPLE) |=> busy_o);

  p_mode_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> ($stable(bip_q) && $stable(fmt_q)));
endmodule

// File: rtl/sar_out_stage.sv
module sar_out_stage #(
  parameter int unsigned W = 8
) (
  input  logic         rst_ni,
  input  logic         ce_ni,
  input  logic         cs_ni,
  input  logic         rw_i,
  input  logic         busy_i,
  input  logic [W-1:0] res_i,
  input  logic         bip_i,
  input  logic         fmt_i,
  output logic [W-1:0] data_o,
  output logic         oe_o
);
  logic [W-1:0] code;

  // two's complement = offset binary with MSB flipped
  assign code   = (bip_i && fmt_i) ? (res_i ^ (W'(1) << (W - 1))) : res_i;
  assign oe_o   = rst_ni && !ce_ni && !cs_ni && rw_i && !busy_i;
  assign data_o = oe_o ? code : 'z;
endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl #(
  parameter int unsigned W       = 8,
  parameter int unsigned MIN_CYC = 15
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ce_ni,
  input  logic         cs_ni,
  input  logic         rw_i,
  input  logic         bipolar_i,
  input  logic         fmt_i,
  input  logic         cmp_i,
  output logic [W-1:0] dac_o,
  output logic         status_o,
  output logic [W-1:0] data_o,
  output logic         data_oe_o
);
  logic         start_req, start;
  logic [W-1:0] res;
  logic         bip_q, fmt_q;

  assign start_req = !ce_ni && !cs_ni && !rw_i;

  sar_start_filter #(.MIN_CYC(MIN_CYC)) u_filt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (start_req),
    .start_o (start)
  );

  sar_seq #(.W(W)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .cmp_i   (cmp_i),
    .bip_i   (bipolar_i),
    .fmt_i   (fmt_i),
    .busy_o  (status_o),
    .trial_o (dac_o),
    .res_o   (res),
    .bip_o   (bip_q),
    .fmt_o   (fmt_q)
  );

  sar_out_stage #(.W(W)) u_out (
    .rst_ni (rst_ni),
    .ce_ni  (ce_ni),
    .cs_ni  (cs_ni),
    .rw_i   (rw_i),
    .busy_i (status_o),
    .res_i  (res),
    .bip_i  (bip_q),
    .fmt_i  (fmt_q),
    .data_o (data_o),
    .oe_o   (data_oe_o)
  );

  p_no_drive_busy_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o |-> !data_oe_o);

  p_read_only_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> (rw_i && !ce_ni && !cs_ni));
endmodule

// File: tb/sim_sar_adc_ctrl.sv
module sim_sar_adc_ctrl;
  localparam int W = 8;
  localparam int MIN_CYC = 15;
  localparam int CONV = 2 * W + 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ce_n = 1'b1, cs_n = 1'b1, rw = 1'b0, bip = 1'b0, fmt = 1'b0;
  logic [W-1:0] vin = '0;
  logic cmp;
  logic [W-1:0] dac, data;
  logic status, oe;
  int checks = 0, failures = 0;
  bit ended = 0;

  always #10 clk = ~clk;

  assign cmp = (dac > vin);

  sar_adc_ctrl #(.W(W), .MIN_CYC(MIN_CYC)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce_n), .cs_ni(cs_n), .rw_i(rw),
    .bipolar_i(bip), .fmt_i(fmt), .cmp_i(cmp), .dac_o(dac),
    .status_o(status), .data_o(data), .data_oe_o(oe));

  function automatic logic [W-1:0] exp_code(logic [W-1:0] v, logic b, logic f);
    return (b && f) ? (v ^ 8'h80) : v;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic bus_idle();
    ce_n = 1'b1; cs_n = 1'b1; rw = 1'b0;
  endtask

  // mode 0: plain, 1: read during busy, 2: start attempt during busy
  task automatic conv(logic [W-1:0] v, logic b, logic f, int mode);
    @(negedge clk);
    vin = v; bip = b; fmt = f;
    ce_n = 1'b0; cs_n = 1'b0; rw = 1'b0;
    repeat (MIN_CYC) @(negedge clk);
    chk("R1 start", status, 1);
    bus_idle();
    bip = ~b; fmt = $urandom_range(0, 1);  // R6: must not matter
    if (mode == 1) begin
      @(negedge clk);
      ce_n = 1'b0; cs_n = 1'b0; rw = 1'b1;
      #1 chk("R5 read blocked busy", oe, 0);
      bus_idle();
      repeat (CONV - 2) @(negedge clk);
    end else if (mode == 2) begin
      @(negedge clk);
      ce_n = 1'b0; cs_n = 1'b0; rw = 1'b0;
      repeat (MIN_CYC) @(negedge clk);
      bus_idle();
    end else begin
      repeat (CONV - 1) @(negedge clk);
    end
    chk("R2 busy last cycle", status, 1);
    @(negedge clk);
    chk("R2 busy end", status, 0);
    if (mode == 2) begin
      repeat (3) @(negedge clk);
      chk("R4 no restart", status, 0);
    end
    ce_n = 1'b0; cs_n = 1'b0; rw = 1'b1;
    #1 chk("R5 read oe", oe, 1);
    chk((b && f) ? "R7 twos" : "R3 R7 code", data, exp_code(v, b, f));
    @(negedge clk);
    cs_n = 1'b1;
    #1 chk("R5 cs high releases", oe, 0);
    bus_idle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      failures++;
      $display("FAIL watchdog act=hang exp=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5a17));
    ce_n = 1'b0; cs_n = 1'b0; rw = 1'b1;
    repeat (3) @(negedge clk);
    chk("R8 status reset", status, 0);
    chk("R8 dac reset", dac, 0);
    chk("R8 oe reset", oe, 0);
    rst_n = 1'b1;
    #1 chk("R8 read after reset", data, 0);
    bus_idle();

    // R1: one cycle short
    @(negedge clk);
    ce_n = 1'b0; cs_n = 1'b0; rw = 1'b0;
    repeat (MIN_CYC - 1) @(negedge clk);
    bus_idle();
    @(negedge clk);
    chk("R1 short pulse", status, 0);
    repeat (3) @(negedge clk);
    chk("R1 short pulse late", status, 0);

    conv(8'h00, 0, 0, 0);
    conv(8'hFF, 0, 1, 0);
    conv(8'h80, 1, 1, 0);
    conv(8'h7F, 1, 0, 0);
    conv(8'h01, 1, 1, 1);
    conv(8'hA5, 1, 1, 2);
    conv(8'h3C, 0, 0, 2);

    // R9: continuous request gives one conversion
    @(negedge clk);
    vin = 8'h55; bip = 1'b0; fmt = 1'b0;
    ce_n = 1'b0; cs_n = 1'b0; rw = 1'b0;
    repeat (MIN_CYC) @(negedge clk);
    chk("R9 first start", status, 1);
    repeat (CONV + 5) @(negedge clk);
    chk("R9 no retrigger", status, 0);
    bus_idle();
    rw = 1'b1; ce_n = 1'b0; cs_n = 1'b0;
    #1 chk("R9 result", data, 8'h55);
    bus_idle();

    for (int i = 0; i < 30; i++)
      conv(W'($urandom), $urandom_range(0, 1), $urandom_range(0, 1),
           $urandom_range(0, 2));

    ended = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule